// File: doc/BRIEF.md
# Translation Fault Status Recorder

This block sits beside the translation engine of one context and keeps a record of the faults that engine reports. Each fault arrives as a one-cycle event carrying a set of fault kind flags, an error code, the table level at which the walk failed and the input address that caused it. The recorder merges the kind flags into a sticky status word. It keeps the address, code and level of the first fault only, until software clears the record.

Software sees three words through a small register port. Word 0 is the status, word 1 is the captured fault address, and word 2 is a control word whose bit 0 enables the interrupt. To clear the record, software writes the value zero to the status word. A write of any other value leaves the record as it was. Clearing also zeroes the captured address, so a handler must read word 1 before it clears word 0. The interrupt output is a level. It stays high while it is enabled and at least one fault flag is held.

Top module: `fault_status_unit`

## Requirements
- R1: Status word flags: bit 0 is a translation fault (`flt_kind[0]`), bit 1 a page fault (`flt_kind[1]`), bit 2 a table-walk abort (`flt_kind[2]`) and bit 4 multiple TLB hits (`flt_kind[3]`). A recorded fault sets its flags in the cycle after it arrives, and all other flag bits read zero.
- R2: Status bits 10:8 return the error code of the first fault and bits 13:12 return its table level. The code values are 1 for a descriptor format error, 4 for a permission error and 5 for a secure-access error.
- R3: Word 1 returns the fault address of the first fault recorded while no flag was set, zero-extended to the word width.
- R4: A write of zero to word 0 clears all flags, the code and the level in the next cycle. A write of a non-zero value to word 0 has no effect.
- R5: A clear of the status also zeroes the captured fault address.
- R6: A fault that arrives while any flag is set only ORs in its kind flags. The address, code and level already held stay unchanged.
- R7: A fault in the same cycle as a clearing write is recorded as a new first fault. Its flags, code, level and address remain after the clear.
- R8: `irq` is high exactly when word 2 bit 0 is set and any flag is held. It falls in the cycle after a clear, and word 2 bit 0 reads back as written.
- R9: After reset every word reads zero and `irq` is low. A fault event whose kind flags are all zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault event strobe |
| flt_kind | input | 4 | Fault kind flags: translation, page, walk abort, multi-hit |
| flt_code | input | 3 | Error code of the event |
| flt_level | input | 2 | Table level of the event |
| flt_addr | input | ADDR_W | Input address that faulted |
| reg_sel | input | 2 | Word select: 0 status, 1 address, 2 control |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected word |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that a fault event and a register write are each valid for exactly one cycle. They also assume that the inputs are stable around the rising edge and that a write to the address word never happens. The bench drives every event on a falling edge and removes it on the next falling edge. It therefore never holds a strobe over two edges, and it writes only to words 0 and 2. The race case is produced on purpose, by raising the fault strobe and the clearing write on the same falling edge.

// File: rtl/fault_status_unit.sv
module fault_status_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic [3:0]        flt_kind,
  input  logic [2:0]        flt_code,
  input  logic [1:0]        flt_level,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  logic [3:0]        flags_q;
  logic [2:0]        code_q;
  logic [1:0]        level_q;
  logic [ADDR_W-1:0] addr_q;
  logic              irq_en_q;

  logic clr, hit, first;
  logic [DATA_W-1:0] stat_word;

  assign clr   = reg_we && (reg_sel == SEL_STAT) && (reg_wdata == '0);
  assign hit   = flt_valid && (flt_kind != 4'b0);
  assign first = hit && (clr || (flags_q == 4'b0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      code_q   <= '0;
      level_q  <= '0;
      addr_q   <= '0;
      irq_en_q <= 1'b0;
    end else begin
      if (clr) begin
        flags_q <= '0;
        code_q  <= '0;
        level_q <= '0;
        addr_q  <= '0;
      end
      if (hit)
        flags_q <= (clr ? 4'b0 : flags_q) | flt_kind;
      if (first) begin
        code_q  <= flt_code;
        level_q <= flt_level;
        addr_q  <= flt_addr;
      end
      if (reg_we && (reg_sel == SEL_CTRL))
        irq_en_q <= reg_wdata[0];
    end
  end

  always_comb begin
    stat_word        = '0;
    stat_word[2:0]   = flags_q[2:0];
    stat_word[4]     = flags_q[3];
    stat_word[10:8]  = code_q;
    stat_word[13:12] = level_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_STAT: reg_rdata = stat_word;
      SEL_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
      SEL_CTRL: reg_rdata[0] = irq_en_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = irq_en_q && (flags_q != 4'b0);
endmodule

module fault_status_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flt_valid,
  input logic [3:0]        flt_kind,
  input logic [ADDR_W-1:0] flt_addr,
  input logic [1:0]        reg_sel,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic [3:0]        flags_q,
  input logic [2:0]        code_q,
  input logic [ADDR_W-1:0] addr_q
);
  logic clr_wr, nz_wr, ev;
  assign clr_wr = reg_we && (reg_sel == 2'd0) && (reg_wdata == '0);
  assign nz_wr  = reg_we && (reg_sel == 2'd0) && (reg_wdata != '0);
  assign ev     = flt_valid && (flt_kind != 4'b0);

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !ev) |=> (flags_q == 4'b0)); // R4
  AST_CLEAR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !ev) |=> (addr_q == '0)); // R5
  AST_NONZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_wr && !ev) |=> $stable(flags_q)); // R4
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && flags_q == 4'b0) |=> (addr_q == $past(flt_addr))); // R3
  AST_KEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && flags_q != 4'b0 && !clr_wr) |=> ($stable(addr_q) && $stable(code_q))); // R6
  AST_RACE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && clr_wr) |=> (flags_q == $past(flt_kind))); // R7
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !ev) |=> !irq); // R8
  AST_EMPTY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_kind == 4'b0 && !reg_we) |=> ($stable(flags_q) && $stable(addr_q))); // R9
endmodule

bind fault_status_unit fault_status_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_kind(flt_kind),
  .flt_addr(flt_addr), .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .irq(irq), .flags_q(flags_q), .code_q(code_q), .addr_q(addr_q)
);

// File: tb/fault_status_unit_tb_top.sv
module fault_status_unit_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_valid = 1'b0;
  logic [3:0] flt_kind = '0;
  logic [2:0] flt_code = '0;
  logic [1:0] flt_level = '0;
  logic [AW-1:0] flt_addr = '0;
  logic [1:0] reg_sel = '0;
  logic reg_we = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  fault_status_unit #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_kind(flt_kind),
    .flt_code(flt_code), .flt_level(flt_level), .flt_addr(flt_addr),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(input logic [3:0] k, input logic [2:0] c, input logic [1:0] l);
    stat = {18'b0, l, 1'b0, c, 3'b0, k[3], 1'b0, k[2:0]};
  endfunction

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic fault(input logic [3:0] k, input logic [2:0] c, input logic [1:0] l, input logic [31:0] a);
    @(negedge clk);
    flt_valid = 1'b1; flt_kind = k; flt_code = c; flt_level = l; flt_addr = a;
    @(negedge clk);
    flt_valid = 1'b0; flt_kind = '0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R9 status after reset", v, 0);
    rd(2'd1, v); check("R9 address after reset", v, 0);
    rd(2'd2, v); check("R9 control after reset", v, 0);
    check("R9 irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_first_fault();
    logic [31:0] v;
    wr(2'd2, 32'h1);
    rd(2'd2, v); check("R8 control readback", v, 1);
    fault(4'b0001, 3'd1, 2'd2, 32'hA000_1000);
    rd(2'd0, v); check("R1 R2 first fault status", v, stat(4'b0001, 3'd1, 2'd2));
    rd(2'd1, v); check("R3 first fault address", v, 32'hA000_1000);
    check("R8 irq with flag and enable", {31'b0, irq}, 1);
  endtask

  task automatic t_accumulate();
    logic [31:0] v;
    fault(4'b1000, 3'd4, 2'd1, 32'hB000_2000);
    rd(2'd0, v); check("R6 R1 flags merge, code and level kept", v, stat(4'b1001, 3'd1, 2'd2));
    rd(2'd1, v); check("R6 address kept", v, 32'hA000_1000);
  endtask

  task automatic t_nonzero_write();
    logic [31:0] v;
    wr(2'd0, 32'h0000_FFFF);
    rd(2'd0, v); check("R4 nonzero write ignored", v, stat(4'b1001, 3'd1, 2'd2));
    rd(2'd1, v); check("R4 address kept on nonzero write", v, 32'hA000_1000);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = '0;
    #1 check("R8 irq held before clear edge", {31'b0, irq}, 1);
    @(negedge clk);
    reg_we = 1'b0;
    check("R8 irq low after clear", {31'b0, irq}, 0);
    rd(2'd0, v); check("R4 status cleared", v, 0);
    rd(2'd1, v); check("R5 address cleared", v, 0);
  endtask

  task automatic t_page_abort();
    logic [31:0] v;
    fault(4'b0110, 3'd5, 2'd3, 32'hC000_3000);
    rd(2'd0, v); check("R1 R2 page and abort status", v, stat(4'b0110, 3'd5, 2'd3));
    rd(2'd1, v); check("R3 address after new first fault", v, 32'hC000_3000);
  endtask

  task automatic t_race();
    logic [31:0] v;
    @(negedge clk);
    flt_valid = 1'b1; flt_kind = 4'b0010; flt_code = 3'd4; flt_level = 2'd0; flt_addr = 32'hD000_4000;
    reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = '0;
    @(negedge clk);
    flt_valid = 1'b0; flt_kind = '0; reg_we = 1'b0;
    rd(2'd0, v); check("R7 fault wins over clear", v, stat(4'b0010, 3'd4, 2'd0));
    rd(2'd1, v); check("R7 racing fault address", v, 32'hD000_4000);
  endtask

  task automatic t_irq_enable();
    wr(2'd2, 32'h0);
    check("R8 irq low when disabled", {31'b0, irq}, 0);
    wr(2'd2, 32'h1);
    check("R8 irq back when enabled", {31'b0, irq}, 1);
  endtask

  task automatic t_empty_event();
    logic [31:0] v;
    wr(2'd0, 32'h0);
    fault(4'b0000, 3'd5, 2'd1, 32'hE000_5000);
    rd(2'd0, v); check("R9 empty event status", v, 0);
    rd(2'd1, v); check("R9 empty event address", v, 0);
    check("R9 empty event irq", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_fault();
    t_accumulate();
    t_nonzero_write();
    t_clear();
    t_page_abort();
    t_race();
    t_irq_enable();
    t_empty_event();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule